// File: doc/BRIEF.md
# Character LCD Nibble-Mode Driver

This block drives a 16-column, 2-row character LCD over a 4-bit data bus with three control lines. A free-running prescaler divides the system clock into slow ticks, so the enable strobe never toggles faster than the panel allows. On every tick the sequencer moves one step through a fixed stream of bytes. The stream starts with four configuration commands, then carries the first row of text, a cursor move to the second row and the second row of text.

Each byte goes out as two nibbles, high nibble first. Each nibble takes three tick slots: a setup slot with enable low and data valid, a strobe slot with enable high, and a hold slot with enable low. After the last nibble of the last character the driver parks in an idle state and drives every line low. A reset restarts the prescaler and the whole stream.

Top module: `lcd_nibble_driver`

## Requirements
- R1: While `rst_ni` is low the control word is 0x00. The first clock edge after release presents the setup slot of the first nibble.
- R2: The control word is laid out as bit 7 reserved (always 0), bit 6 enable, bit 5 read/write (always 0, write only), bit 4 register select, bits 3:0 data nibble.
- R3: The sequence advances one slot every `TICK_DIV` clock cycles, so every enable pulse is high for exactly `TICK_DIV` cycles.
- R4: Each nibble occupies three slots in the order setup (enable 0), strobe (enable 1), hold (enable 0). Data and register select are unchanged across all three.
- R5: Each byte is sent high nibble first (bits 7:4), then low nibble (bits 3:0), with a separate enable pulse for each.
- R6: The stream begins with the commands 0x28 (4-bit bus, two lines), 0x0C (display on, cursor off), 0x01 (clear) and 0x06 (increment entry), all with register select 0.
- R7: The commands are followed by the `COLS` characters of `LINE_TOP` (leftmost character in the most significant byte), the command 0xC0 (cursor to address 0x40), then the `COLS` characters of `LINE_BOT`. Characters carry register select 1; the cursor command carries register select 0.
- R8: Once the final nibble's hold slot ends, the driver stays idle and the control word stays 0x00 until the next reset.
- R9: Asserting reset in the middle of the stream restarts it from the first command with a fresh prescaler count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| lcd_ctrl_o | output | 8 | Registered control word: reserved, enable, read/write, register select, data nibble |

## Verification
Two states are hard to reach from the ports: the idle state after the final character, and a reset that lands partway through a byte. At the default divider the stream takes millions of cycles. The bench therefore shrinks `TICK_DIV` to a handful of cycles, which brings the whole 37-byte stream within reach. It first cuts a run short with a reset that falls mid-way through a character. It then lets a second run play out to idle and holds there long enough to confirm the lines stay low. Every cycle is compared against a slot-arithmetic model derived from the cycle count since reset.

// File: rtl/lcd_pkg.sv
package lcd_pkg;
  typedef struct packed {
    logic       rsv;
    logic       en;
    logic       rw;
    logic       rs;
    logic [3:0] data;
  } lcd_word_t;

  localparam int unsigned NUM_INIT   = 4;
  localparam logic [7:0]  CMD_FUNC   = 8'h28;
  localparam logic [7:0]  CMD_DISP   = 8'h0C;
  localparam logic [7:0]  CMD_CLEAR  = 8'h01;
  localparam logic [7:0]  CMD_ENTRY  = 8'h06;
  localparam logic [7:0]  CMD_ROW2   = 8'hC0;

  // six slots per byte: setup/strobe/hold for each nibble
  localparam int unsigned SLOTS_PER_NIB = 3;
  localparam int unsigned SLOTS_PER_BYTE = 2 * SLOTS_PER_NIB;

  typedef enum logic {ST_RUN, ST_IDLE} seq_st_e;
endpackage

// File: rtl/lcd_prescaler.sv
module lcd_prescaler #(
  parameter int unsigned TICK_DIV = 50000
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int unsigned CNT_W = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(TICK_DIV - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (cnt_q == CNT_MAX) cnt_q <= '0;
    else                     cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = (cnt_q == CNT_MAX);
endmodule

// File: rtl/lcd_byte_rom.sv
module lcd_byte_rom
  import lcd_pkg::*;
#(
  parameter int unsigned        COLS     = 16,
  parameter int unsigned        IDX_W    = 6,
  parameter logic [8*COLS-1:0]  LINE_TOP = '0,
  parameter logic [8*COLS-1:0]  LINE_BOT = '0
) (
  input  logic [IDX_W-1:0] idx_i,
  output logic [7:0]       byte_o,
  output logic             rs_o
);
  localparam int unsigned TOP_BASE = NUM_INIT;
  localparam int unsigned ROW2_IDX = NUM_INIT + COLS;
  localparam int unsigned BOT_BASE = ROW2_IDX + 1;

  always_comb begin
    int unsigned i;
    i      = int'(idx_i);
    byte_o = 8'h00;
    rs_o   = 1'b0;
    if (i < NUM_INIT) begin
      case (i)
        0:       byte_o = CMD_FUNC;
        1:       byte_o = CMD_DISP;
        2:       byte_o = CMD_CLEAR;
        default: byte_o = CMD_ENTRY;
      endcase
    end else if (i < ROW2_IDX) begin
      byte_o = LINE_TOP[8*(COLS-1-(i-TOP_BASE)) +: 8];
      rs_o   = 1'b1;
    end else if (i == ROW2_IDX) begin
      byte_o = CMD_ROW2;
    end else if (i < BOT_BASE + COLS) begin
      byte_o = LINE_BOT[8*(COLS-1-(i-BOT_BASE)) +: 8];
      rs_o   = 1'b1;
    end
  end
endmodule

// File: rtl/lcd_nibble_fsm.sv
module lcd_nibble_fsm
  import lcd_pkg::*;
#(
  parameter int unsigned NBYTES = 37,
  parameter int unsigned IDX_W  = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  output logic [IDX_W-1:0] idx_o,
  output logic [2:0]       slot_o,
  output logic             idle_o
);
  localparam logic [2:0]       SLOT_LAST = 3'(SLOTS_PER_BYTE - 1);
  localparam logic [IDX_W-1:0] IDX_LAST  = IDX_W'(NBYTES - 1);

  seq_st_e          st_q;
  logic [2:0]       slot_q;
  logic [IDX_W-1:0] idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_RUN;
      slot_q <= '0;
      idx_q  <= '0;
    end else if (tick_i && st_q == ST_RUN) begin
      if (slot_q == SLOT_LAST) begin
        slot_q <= '0;
        if (idx_q == IDX_LAST) st_q  <= ST_IDLE;
        else                   idx_q <= idx_q + 1'b1;
      end else begin
        slot_q <= slot_q + 1'b1;
      end
    end
  end

  assign idx_o  = idx_q;
  assign slot_o = slot_q;
  assign idle_o = (st_q == ST_IDLE);
endmodule

// File: rtl/lcd_nibble_driver.sv
module lcd_nibble_driver
  import lcd_pkg::*;
#(
  parameter int unsigned       TICK_DIV = 50000,
  parameter int unsigned       COLS     = 16,
  parameter logic [8*COLS-1:0] LINE_TOP = "NIBBLE LINK UP  ",
  parameter logic [8*COLS-1:0] LINE_BOT = "4BIT BUS 2 LINES"
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  output logic [7:0] lcd_ctrl_o
);
  localparam int unsigned NBYTES = NUM_INIT + 2 * COLS + 1;
  localparam int unsigned IDX_W  = $clog2(NBYTES + 1);

  logic             tick;
  logic [IDX_W-1:0] byte_idx;
  logic [2:0]       slot;
  logic             idle;
  logic [7:0]       cur_byte;
  logic             cur_rs;
  lcd_word_t        word_d, word_q;

  lcd_prescaler #(.TICK_DIV(TICK_DIV)) u_presc (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_o(tick)
  );

  lcd_nibble_fsm #(.NBYTES(NBYTES), .IDX_W(IDX_W)) u_fsm (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_i(tick),
    .idx_o (byte_idx),
    .slot_o(slot),
    .idle_o(idle)
  );

  lcd_byte_rom #(
    .COLS(COLS), .IDX_W(IDX_W), .LINE_TOP(LINE_TOP), .LINE_BOT(LINE_BOT)
  ) u_rom (
    .idx_i (byte_idx),
    .byte_o(cur_byte),
    .rs_o  (cur_rs)
  );

  always_comb begin
    logic hi_half;
    hi_half = (slot < 3'(SLOTS_PER_NIB));
    word_d  = '0;
    if (!idle) begin
      word_d.en   = (slot == 3'd1) || (slot == 3'd4);
      word_d.rs   = cur_rs;
      word_d.data = hi_half ? cur_byte[7:4] : cur_byte[3:0];
    end
  end

  // registered so enable cannot glitch against data
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) word_q <= '0;
    else         word_q <= word_d;
  end

  assign lcd_ctrl_o = word_q;
endmodule

// File: rtl/lcd_nibble_checker.sv
module lcd_nibble_checker #(
  parameter int unsigned TICK_DIV = 50000,
  parameter int unsigned COLS     = 16,
  parameter int unsigned IDX_W    = 6
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             tick_i,
  input logic             idle_i,
  input logic [IDX_W-1:0] idx_i,
  input logic [7:0]       ctrl_i
);
  localparam int unsigned NBYTES = 4 + 2 * COLS + 1;

  int unsigned gap_q;
  int unsigned hi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_q <= 0;
      hi_q  <= 0;
    end else begin
      gap_q <= tick_i ? 0 : gap_q + 1;
      hi_q  <= ctrl_i[6] ? hi_q + 1 : 0;
    end
  end

  AST_TICK_SPACING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |-> gap_q == TICK_DIV - 1); // R3
  AST_EN_WIDTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ctrl_i[6]) |-> hi_q == TICK_DIV); // R3
  AST_SETUP_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ctrl_i[6]) |-> $stable(ctrl_i[4:0])); // R4
  AST_HOLD_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ctrl_i[6]) |-> $stable(ctrl_i[4:0])); // R4
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_i |=> ctrl_i == 8'h00); // R8
  AST_IDLE_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_i |=> idle_i); // R8
  AST_IDX_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(idx_i) < NBYTES); // R7
endmodule

bind lcd_nibble_driver lcd_nibble_checker #(
  .TICK_DIV(TICK_DIV), .COLS(COLS), .IDX_W(IDX_W)
) u_chk (
  .clk_i (clk_i),
  .rst_ni(rst_ni),
  .tick_i(tick),
  .idle_i(idle),
  .idx_i (byte_idx),
  .ctrl_i(lcd_ctrl_o)
);

// File: tb/lcd_nibble_driver_test.sv
module lcd_nibble_driver_test;
  localparam int unsigned DIV   = 5;
  localparam int unsigned NCOLS = 16;
  localparam logic [8*NCOLS-1:0] TOP_TXT = "Row one: hello! ";
  localparam logic [8*NCOLS-1:0] BOT_TXT = "second row ~ok~ ";
  localparam int unsigned TOTAL_SLOTS = (4 + 2 * NCOLS + 1) * 6;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] ctrl;

  int unsigned edges = 0;
  int errors = 0, checks = 0;
  bit done = 0;
  byte unsigned stream[$];

  always #4 clk = ~clk;

  lcd_nibble_driver #(
    .TICK_DIV(DIV), .COLS(NCOLS), .LINE_TOP(TOP_TXT), .LINE_BOT(BOT_TXT)
  ) uut (
    .clk_i(clk), .rst_ni(rst_n), .lcd_ctrl_o(ctrl)
  );

  always @(posedge clk or negedge rst_n)
    if (!rst_n) edges <= 0;
    else        edges <= edges + 1;

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s edge=%0d actual=%02h expected=%02h", req, edges, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_word(int unsigned s);
    int unsigned g, n, sub, b;
    logic [7:0] w;
    logic rs;
    if (s == 0) return 8'h00;
    g = (s - 1) / DIV;
    if (g >= TOTAL_SLOTS) return 8'h00;
    n   = g / 3;
    sub = g % 3;
    b   = n / 2;
    rs  = (b >= 4 && b < 4 + NCOLS) || (b > 4 + NCOLS);
    w   = 8'(stream[b]);
    return {1'b0, sub == 1, 1'b0, rs, (n % 2 == 0) ? w[7:4] : w[3:0]};
  endfunction

  function automatic string region(int unsigned s);
    int unsigned b;
    if (s == 0) return "R1";
    if ((s - 1) / DIV >= TOTAL_SLOTS) return "R8";
    b = (s - 1) / DIV / 6;
    return (b < 4) ? "R6" : "R7";
  endfunction

  task automatic summary;
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  // runs n cycles comparing every cycle; tracks enable pulses
  int unsigned en_run = 0, pulses = 0;
  logic [4:0] held;
  task automatic run(input int unsigned n, input string tag);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      chk({region(edges), tag}, ctrl, exp_word(edges));
      chk("R2", {ctrl[7], ctrl[5]} == 2'b00, 1'b1);
      if (ctrl[6]) begin
        if (en_run == 0) begin
          held = ctrl[4:0];
          pulses++;
          if (pulses == 1) chk("R5 first hi nibble", {3'b0, ctrl[4:0]}, 8'h02);
          if (pulses == 2) chk("R5 first lo nibble", {3'b0, ctrl[4:0]}, 8'h08);
        end else begin
          chk("R4", {3'b0, ctrl[4:0]}, {3'b0, held});
        end
        en_run++;
      end else if (en_run != 0) begin
        chk("R3", 8'(en_run), 8'(DIV));
        chk("R4 hold", {3'b0, ctrl[4:0]}, {3'b0, held});
        en_run = 0;
      end
    end
  endtask

  initial begin
    stream.push_back(8'h28); stream.push_back(8'h0C);
    stream.push_back(8'h01); stream.push_back(8'h06);
    for (int i = NCOLS - 1; i >= 0; i--) stream.push_back(TOP_TXT[8*i +: 8]);
    stream.push_back(8'hC0);
    for (int i = NCOLS - 1; i >= 0; i--) stream.push_back(BOT_TXT[8*i +: 8]);

    repeat (3) @(negedge clk);
    chk("R1", ctrl, 8'h00);
    rst_n = 1'b1;
    run(2, "");
    chk("R1 first setup", ctrl, 8'h02);
    run(400, "");
    // reset lands mid-character
    rst_n = 1'b0;
    en_run = 0; pulses = 0;
    #1;
    chk("R9 reset clears", ctrl, 8'h00);
    repeat (3) @(negedge clk);
    chk("R9", ctrl, 8'h00);
    rst_n = 1'b1;
    run(TOTAL_SLOTS * DIV + 60, " R9");
    chk("R8", ctrl, 8'h00);
    chk("R3 pulse count", 8'(pulses), 8'(2 * stream.size()));
    summary();
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    summary();
  end
endmodule